// File: doc/BRIEF.md
# Sequential Mini-Calculator with Controller

This block is a small 8-bit calculator run by a control state machine. An 8-bit operand bus is shared by both operands and a 2-bit code selects the operation. A single Enter button steps the block through its sequence. The first Enter event captures operand A together with the operation code.

Addition and bitwise OR take a second Enter event, which captures operand B. The two shift operations use only A, so the controller goes straight to the compute step. The result is registered and held until the next computation. It drives an 8-bit LED bus and two active-low 7-segment hex digits, one digit for each nibble.

The Enter input is synchronized and edge-detected, so a press that is held for many cycles counts as one event. The reset is active low and asynchronous.

Top module: `mini_calc`

## Requirements
- R1: While reset is low and after it is released, the result is 0x00. The LED bus reads 0x00 and both digits show "0" (segment output 7'h40).
- R2: Operation code 2'b00 gives (A + B) mod 256. There is no carry output, so 0x7F + 0x85 gives 0x04.
- R3: Operation code 2'b01 gives A | B.
- R4: Operation code 2'b10 gives A shifted right by one bit, with a zero entering bit 7. 0x93 gives 0x49.
- R5: Operation code 2'b11 gives A shifted left by one bit, with bit 7 dropped and a zero entering bit 0. 0x93 gives 0x26.
- R6: For codes 2'b10 and 2'b11 the result updates after a single Enter event. The next Enter event captures a new operand A.
- R7: For codes 2'b00 and 2'b01 the result keeps its previous value after the first Enter event. It updates only after a second Enter event, which captures B.
- R8: Enter held high for many cycles counts as exactly one event.
- R9: The operation code is sampled only on the event that captures A. Changes to the code before the B event have no effect on the result.
- R10: Each digit output is active low, with bit 6 = g down to bit 0 = a. Written active-high as gfedcba, the digits 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. The upper digit shows result[7:4] and the lower digit shows result[3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enter | input | 1 | Enter button level, asynchronous |
| operand | input | 8 | Shared operand bus |
| op_sel | input | 2 | Operation code |
| led | output | 8 | Result |
| hex_hi | output | 7 | Upper nibble digit, active low, g..a |
| hex_lo | output | 7 | Lower nibble digit, active low, g..a |

## Verification
The hardest situation to create from the ports is a long Enter press during an add. A controller that counted levels instead of edges would run on through the B capture and compute with whatever happens to be on the bus. The stimulus holds Enter for thirty cycles after selecting add, then confirms that the LEDs still show the previous result. A second, separate press then produces the correct sum. A related check changes the operation code between the A and B events and confirms that the result follows the latched code.

// File: rtl/mini_calc.sv
module mini_calc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  logic [7:0] operand,
  input  logic [1:0] op_sel,
  output logic [7:0] led,
  output logic [6:0] hex_hi,
  output logic [6:0] hex_lo
);

  typedef enum logic [1:0] {S_A, S_B, S_CALC} state_t;

  state_t     state;
  logic [2:0] ent_q;
  logic       press;
  logic [7:0] a_q, b_q, res_q, res_d;
  logic [1:0] op_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ent_q <= '0;
    else        ent_q <= {ent_q[1:0], enter};

  assign press = ent_q[1] & ~ent_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_A;
      a_q   <= '0;
      b_q   <= '0;
      op_q  <= '0;
      res_q <= '0;
    end else begin
      case (state)
        S_A: if (press) begin
          a_q   <= operand;
          op_q  <= op_sel;
          state <= op_sel[1] ? S_CALC : S_B;
        end
        S_B: if (press) begin
          b_q   <= operand;
          state <= S_CALC;
        end
        default: begin
          res_q <= res_d;
          state <= S_A;
        end
      endcase
    end

  always_comb
    case (op_q)
      2'b00:   res_d = a_q + b_q;
      2'b01:   res_d = a_q | b_q;
      2'b10:   res_d = {1'b0, a_q[7:1]};
      default: res_d = {a_q[6:0], 1'b0};
    endcase

  function automatic logic [6:0] seg7(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  assign led    = res_q;
  assign hex_hi = seg7(res_q[7:4]);
  assign hex_lo = seg7(res_q[3:0]);

  assert_shift_skips_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_A && press && op_sel[1]) |=> (state == S_CALC));

  assert_two_operand_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_A && press && !op_sel[1]) |=> (state == S_B));

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_CALC) |=> $stable(led));

  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);

  assert_op_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_B) |=> $stable(op_q));

endmodule

// File: tb/test_mini_calc.sv
module test_mini_calc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enter = 1'b0;
  logic [7:0] operand = '0;
  logic [1:0] op_sel = '0;
  logic [7:0] led;
  logic [6:0] hex_hi, hex_lo;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mini_calc i_mini_calc (
    .clk(clk), .rst_n(rst_n), .enter(enter), .operand(operand),
    .op_sel(op_sel), .led(led), .hex_hi(hex_hi), .hex_lo(hex_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] digit_ref(input logic [3:0] d);
    logic [6:0] lit [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~lit[d];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [7:0] exp);
    check(req, led, exp);
    check("R10 hi", {1'b0, hex_hi}, {1'b0, digit_ref(exp[7:4])});
    check("R10 lo", {1'b0, hex_lo}, {1'b0, digit_ref(exp[3:0])});
  endtask

  task automatic press(input logic [7:0] val, input logic [1:0] op, input int hold);
    @(negedge clk);
    operand = val;
    op_sel  = op;
    enter   = 1'b1;
    repeat (hold) @(negedge clk);
    enter = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_result("R1 in reset", 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_result("R1 after reset", 8'h00);
  endtask

  task automatic t_add;
    press(8'h7F, 2'b00, 3);
    check_result("R7 held after A", 8'h00);
    press(8'h85, 2'b00, 3);
    check_result("R2 add wraps", 8'h04);
    press(8'h12, 2'b00, 3);
    press(8'h34, 2'b00, 3);
    check_result("R2 add", 8'h46);
  endtask

  task automatic t_or;
    press(8'hA0, 2'b01, 3);
    check_result("R7 OR held after A", 8'h46);
    press(8'h05, 2'b01, 3);
    check_result("R3 or", 8'hA5);
  endtask

  task automatic t_shifts;
    press(8'h93, 2'b10, 3);
    check_result("R4 shift right", 8'h49);
    press(8'h93, 2'b11, 3);
    check_result("R5 shift left", 8'h26);
    press(8'h81, 2'b10, 3);
    check_result("R6 next press is new A", 8'h40);
    press(8'hFF, 2'b11, 3);
    check_result("R5 msb dropped", 8'hFE);
  endtask

  task automatic t_long_press;
    press(8'h10, 2'b00, 30);
    check_result("R8 long press one event", 8'hFE);
    press(8'h22, 2'b00, 3);
    check_result("R8 sum after long press", 8'h32);
  endtask

  task automatic t_op_latch;
    press(8'h0F, 2'b01, 3);
    press(8'hF0, 2'b11, 3);
    check_result("R9 op latched at A", 8'hFF);
    press(8'h03, 2'b00, 3);
    press(8'h05, 2'b01, 3);
    check_result("R9 add kept", 8'h08);
  endtask

  task automatic t_digits;
    for (int i = 0; i < 16; i++) begin
      press(8'(i * 17), 2'b01, 2);
      press(8'h00, 2'b01, 2);
      check_result("R10 digit sweep", 8'(i * 17));
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_or();
    t_shifts();
    t_long_press();
    t_op_latch();
    t_digits();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule